// File: doc/BRIEF.md
# Cascadable Dual Reload Timer

This block holds two 32-bit down-counters, each paired with a reload register that sets its period. A counter that is running steps down by one on each of its ticks. When it sits at zero, the next tick reloads it from its reload register and marks an expiry. An expiry sets that timer's interrupt flag. It can also drive the timer's external timeout line, either as a one-clock pulse or as a level that holds until software clears it. A timer is either periodic or one-shot. A one-shot timer clears its own run bit when it expires.

A global cascade bit chains the pair. With cascade set, the second counter ticks only in a cycle where the first counter expires, so the two counters together measure one long interval. With cascade clear, both counters tick on every clock.

All access goes through a byte-wide bus. Writes are synchronous and reads are combinational. A reload value is written one byte at a time into staging storage. The write to its top byte moves all four bytes into the reload register and into the counter in one step.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every counter, reload register, control field, cascade bit, interrupt flag and timeout line reads or drives 0.
- R2: Reload bytes sit at addresses 0–3 (timer 0) and 4–7 (timer 1), least significant byte first. Writing the three low bytes changes neither the reload readback nor the counter. Writing the top byte (address 3 or 7) loads {top byte, staged bytes} into both the reload register and the counter at the same clock edge.
- R3: A timer whose run bit is set and whose tick is present decrements by one per tick. A timer whose run bit is clear holds its count. Counts read back at addresses 8–11 (timer 0) and 12–15 (timer 1), least significant byte first.
- R4: A running timer at zero reloads from its reload register on its next tick and expires on that tick, which gives a period of reload+1 ticks. A top-byte write in the same cycle takes priority over that reload.
- R5: Control registers sit at addresses 16 (timer 0) and 17 (timer 1): bit0 run, bit1 periodic (1) or one-shot (0), bit2 timeout-line enable, bit3 latched line mode. On expiry a one-shot timer clears its own run bit. A control write in the same cycle wins.
- R6: The global register at address 18, bit0, selects cascade. When it is set, timer 1 ticks only in cycles where timer 0 expires.
- R7: An expiry sets the interrupt flag, which shows on tmr_irq and at address 19 (bit k for timer k). Writing 1 to bit k clears flag k. Writing 0 has no effect. If an expiry and a clear fall in the same cycle, the expiry wins.
- R8: With the line enabled and latched mode off, tmr_tout[k] is high for exactly the one cycle after each expiry. With the line disabled it stays low.
- R9: With the line enabled and latched mode on, tmr_tout[k] rises after an expiry and stays high until the flag-clear write for that timer.
- R10: Reads of addresses 20–31 return 0. Writes to the count addresses or to unmapped addresses change nothing. Control readback has bits 7:4 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 5 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tmr_tout | output | 2 | Timeout lines, bit k for timer k |
| tmr_irq | output | 2 | Interrupt flags, bit k for timer k |

## Verification
Read data follows bus_addr in the same cycle. A written register, a counter step, an interrupt flag and a timeout line all change at the first clock edge after the cycle that caused them. Expiry therefore appears on tmr_irq and tmr_tout one edge after the cycle in which a running counter sat at zero with its tick present. The bench drives inputs just after the rising edge and moves a behavioural model of the block forward on that same edge. It compares every output at the falling edge, half a cycle later, when each result due from the last edge is already present. Internal reset release lags rst_n by two edges, so the bench waits several idle cycles before its first write.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int NT = 2;

  typedef struct packed {
    logic latch;     // timeout line holds until cleared
    logic pin_en;    // timeout line enable
    logic periodic;  // 1 periodic, 0 one-shot
    logic run;       // counter enable
  } tmr_ctl_t;
endpackage

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign step    = run & tick;
  assign expire  = step & at_zero;
  assign cnt     = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (step)
      cnt_d = at_zero ? reload : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load | step)
      cnt_q <= cnt_d;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(run && tick)) |=> $stable(cnt_q)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && run && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R3
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && run && tick && cnt_q == '0) |=> cnt_q == $past(reload)); // R4
endmodule

// File: rtl/dtmr_flags.sv
module dtmr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  input  logic pin_en,
  input  logic latch,
  output logic irq,
  output logic tout
);
  logic irq_q, irq_d;
  logic out_q, out_d;

  always_comb begin
    irq_d = irq_q;
    if (clr)
      irq_d = 1'b0;
    if (expire)
      irq_d = 1'b1;
  end

  always_comb begin
    if (!pin_en)
      out_d = 1'b0;
    else if (latch)
      out_d = (out_q & ~clr) | expire;
    else
      out_d = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      out_q <= out_d;
    end
  end

  assign irq  = irq_q;
  assign tout = out_q;

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_q); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr) |=> irq_q); // R7
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire && !latch) |=> !out_q); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en && latch && out_q && !clr) |=> out_q); // R9
endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NT-1:0]     expire,
  input  logic [NT-1:0]     irq,
  input  logic [CNT_W-1:0]  cnt        [NT],
  output logic [CNT_W-1:0]  reload     [NT],
  output logic [NT-1:0]     commit,
  output logic [CNT_W-1:0]  commit_val [NT],
  output tmr_ctl_t          ctl        [NT],
  output logic              casc,
  output logic [NT-1:0]     clr
);
  localparam int NBYTE    = CNT_W / 8;
  localparam int STG_W    = (NBYTE - 1) * 8;
  localparam int CNT_BASE = NT * NBYTE;
  localparam int CTL_BASE = 2 * NT * NBYTE;
  localparam int GLB_ADDR = CTL_BASE + NT;
  localparam int STS_ADDR = GLB_ADDR + 1;

  logic [STG_W-1:0] stage_q  [NT];
  logic [STG_W-1:0] stage_d  [NT];
  logic [CNT_W-1:0] reload_q [NT];
  tmr_ctl_t         ctl_q    [NT];
  tmr_ctl_t         ctl_d    [NT];
  logic [NT-1:0]    ctl_wr;
  logic             casc_q, casc_d;
  int               a;

  assign a = int'(addr);

  always_comb begin
    for (int k = 0; k < NT; k++) begin
      stage_d[k] = stage_q[k];
      for (int b = 0; b < NBYTE - 1; b++)
        if (we && a == k * NBYTE + b)
          stage_d[k][8*b +: 8] = wdata;
      commit[k]     = we && (a == k * NBYTE + NBYTE - 1);
      commit_val[k] = {wdata, stage_q[k]};
      ctl_wr[k]     = we && (a == CTL_BASE + k);
      clr[k]        = we && (a == STS_ADDR) && wdata[k];
      ctl_d[k]      = ctl_q[k];
      if (expire[k] && !ctl_q[k].periodic)
        ctl_d[k].run = 1'b0;
      if (ctl_wr[k])
        ctl_d[k] = tmr_ctl_t'(wdata[3:0]);
    end
    casc_d = (we && a == GLB_ADDR) ? wdata[0] : casc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) begin
        stage_q[k]  <= '0;
        reload_q[k] <= '0;
        ctl_q[k]    <= '0;
      end
      casc_q <= 1'b0;
    end else begin
      for (int k = 0; k < NT; k++) begin
        stage_q[k] <= stage_d[k];
        if (commit[k])
          reload_q[k] <= commit_val[k];
        ctl_q[k] <= ctl_d[k];
      end
      casc_q <= casc_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NT; k++) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (a == k * NBYTE + b)
          rdata = reload_q[k][8*b +: 8];
        if (a == CNT_BASE + k * NBYTE + b)
          rdata = cnt[k][8*b +: 8];
      end
      if (a == CTL_BASE + k)
        rdata = {4'b0000, ctl_q[k]};
    end
    if (a == GLB_ADDR)
      rdata = {7'b0, casc_q};
    if (a == STS_ADDR)
      rdata = 8'(irq);
  end

  assign reload = reload_q;
  assign ctl    = ctl_q;
  assign casc   = casc_q;

  for (genvar k = 0; k < NT; k++) begin : g_chk
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[k] && !ctl_q[k].periodic && !ctl_wr[k]) |=> !ctl_q[k].run); // R5
    AST_RELOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !commit[k] |=> $stable(reload_q[k])); // R2
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [NT-1:0]     tmr_tout,
  output logic [NT-1:0]     tmr_irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [CNT_W-1:0] cnt        [NT];
  logic [CNT_W-1:0] reload     [NT];
  logic [CNT_W-1:0] commit_val [NT];
  logic [NT-1:0]    commit;
  logic [NT-1:0]    expire;
  logic [NT-1:0]    tick;
  logic [NT-1:0]    clr;
  tmr_ctl_t         ctl        [NT];
  logic             casc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  dtmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_ni),
    .we         (bus_we),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .rdata      (bus_rdata),
    .expire     (expire),
    .irq        (tmr_irq),
    .cnt        (cnt),
    .reload     (reload),
    .commit     (commit),
    .commit_val (commit_val),
    .ctl        (ctl),
    .casc       (casc),
    .clr        (clr)
  );

  for (genvar k = 0; k < NT; k++) begin : g_tmr
    if (k == 0) begin : g_free
      assign tick[k] = 1'b1;
    end else begin : g_chain
      assign tick[k] = casc ? expire[k-1] : 1'b1;
    end

    dtmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_ni),
      .run      (ctl[k].run),
      .tick     (tick[k]),
      .load     (commit[k]),
      .load_val (commit_val[k]),
      .reload   (reload[k]),
      .cnt      (cnt[k]),
      .expire   (expire[k])
    );

    dtmr_flags u_flg (
      .clk    (clk),
      .rst_n  (rst_ni),
      .expire (expire[k]),
      .clr    (clr[k]),
      .pin_en (ctl[k].pin_en),
      .latch  (ctl[k].latch),
      .irq    (tmr_irq[k]),
      .tout   (tmr_tout[k])
    );
  end

  AST_CASCADE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (casc && !expire[0] && !commit[1]) |=> $stable(cnt[1])); // R6
endmodule

// File: tb/sim_dual_reload_timer.sv
`timescale 1ns/1ps
module sim_dual_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_we;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] tmr_tout;
  logic [1:0] tmr_irq;

  always #10 clk = ~clk;

  dual_reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_tout(tmr_tout), .tmr_irq(tmr_irq)
  );

  int    vectors = 0;
  int    fails   = 0;
  bit    checking = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [31:0] m_cnt [2];
  logic [31:0] m_rel [2];
  logic [7:0]  m_stg [2][3];
  logic [3:0]  m_ctl [2];
  logic        m_casc;
  logic [1:0]  m_irq, m_out;
  logic        e0, e1, tk;
  logic [1:0]  ee, clrv;

  function automatic logic [7:0] m_read(input int a);
    if (a < 8)       return m_rel[a / 4][8 * (a % 4) +: 8];
    else if (a < 16) return m_cnt[(a - 8) / 4][8 * (a % 4) +: 8];
    else if (a == 16) return {4'b0, m_ctl[0]};
    else if (a == 17) return {4'b0, m_ctl[1]};
    else if (a == 18) return {7'b0, m_casc};
    else if (a == 19) return {6'b0, m_irq};
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_rel[k] = 0; m_ctl[k] = 0;
        for (int b = 0; b < 3; b++) m_stg[k][b] = 0;
      end
      m_casc = 0; m_irq = 0; m_out = 0;
    end else begin
      e0 = m_ctl[0][0] && (m_cnt[0] == 0);
      e1 = m_ctl[1][0] && (m_casc ? e0 : 1'b1) && (m_cnt[1] == 0);
      ee = {e1, e0};
      clrv = (bus_we && bus_addr == 19) ? bus_wdata[1:0] : 2'b00;
      for (int k = 0; k < 2; k++) begin
        if (!m_ctl[k][2])      m_out[k] = 0;
        else if (m_ctl[k][3])  m_out[k] = (m_out[k] & ~clrv[k]) | ee[k];
        else                   m_out[k] = ee[k];
        m_irq[k] = (m_irq[k] & ~clrv[k]) | ee[k];
        tk = (k == 0) ? 1'b1 : (m_casc ? e0 : 1'b1);
        if (m_ctl[k][0] && tk)
          m_cnt[k] = (m_cnt[k] == 0) ? m_rel[k] : m_cnt[k] - 1;
        if (ee[k] && !m_ctl[k][1]) m_ctl[k][0] = 0;
      end
      if (bus_we) begin
        if (bus_addr < 8) begin
          if (bus_addr % 4 < 3) m_stg[bus_addr / 4][bus_addr % 4] = bus_wdata;
          else begin
            m_rel[bus_addr / 4] = {bus_wdata, m_stg[bus_addr / 4][2],
                                   m_stg[bus_addr / 4][1], m_stg[bus_addr / 4][0]};
            m_cnt[bus_addr / 4] = m_rel[bus_addr / 4];
          end
        end
        else if (bus_addr == 16) m_ctl[0] = bus_wdata[3:0];
        else if (bus_addr == 17) m_ctl[1] = bus_wdata[3:0];
        else if (bus_addr == 18) m_casc   = bus_wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      vectors++;
      if (tmr_tout !== m_out) begin
        fails++;
        $display("FAIL %s tmr_tout act=%b exp=%b t=%0t", cur_req, tmr_tout, m_out, $time);
      end
      if (tmr_irq !== m_irq) begin
        fails++;
        $display("FAIL %s tmr_irq act=%b exp=%b t=%0t", cur_req, tmr_irq, m_irq, $time);
      end
      if (bus_rdata !== m_read(int'(bus_addr))) begin
        fails++;
        $display("FAIL %s rdata@%0d act=%h exp=%h t=%0t", cur_req, bus_addr,
                 bus_rdata, m_read(int'(bus_addr)), $time);
      end
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic look(input int a, input int n);
    bus_addr = 5'(a);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL %s watchdog act=hung exp=finished", cur_req);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    @(posedge clk); #2; checking = 1;
    repeat (3) @(posedge clk); #2;
    rst_n = 1'b1;
    look(0, 5);

    cur_req = "R1";                       // reset values at every address
    for (int i = 0; i < 32; i++) look(i, 1);

    cur_req = "R2";                       // staging does not commit
    wr(0, 8'h05); wr(1, 8'h00); wr(2, 8'h00);
    look(0, 2); look(8, 2);
    wr(3, 8'h00);                         // top byte commits reload and count
    look(0, 2); look(8, 2);

    cur_req = "R3";                       // decrement while running, hold when stopped
    look(8, 1);
    wr(16, 8'h03); look(8, 3);
    wr(16, 8'h00); look(8, 4);
    wr(17, 8'h03); look(12, 10); wr(17, 8'h00);

    cur_req = "R4";                       // reload at zero, period reload+1
    wr(16, 8'h03); look(8, 14);

    cur_req = "R8";                       // pulse line, then line disabled
    wr(16, 8'h07); look(8, 14);
    wr(16, 8'h03); look(8, 8);

    cur_req = "R7";                       // write 0 no effect, write 1 clears
    wr(19, 8'h00); look(19, 2);
    wr(19, 8'h01); look(19, 2);
    wr(0, 8'h00); wr(3, 8'h00);           // reload 0: expiry every cycle
    look(19, 3);
    wr(19, 8'h01); look(19, 2);           // set beats clear
    wr(16, 8'h00); wr(19, 8'h03); look(19, 2);

    cur_req = "R9";                       // latched line until clear
    wr(0, 8'h04); wr(3, 8'h00);
    wr(16, 8'h0F); look(8, 12);
    wr(16, 8'h0C); look(8, 3);
    wr(19, 8'h01); look(19, 3);

    cur_req = "R5";                       // one-shot stops itself
    wr(16, 8'h00);
    wr(0, 8'h03); wr(3, 8'h00);
    wr(16, 8'h05); look(16, 10); look(8, 3);
    wr(19, 8'h03);

    cur_req = "R6";                       // cascade: timer 1 ticks on timer 0 expiry
    wr(0, 8'h02); wr(3, 8'h00);
    wr(4, 8'h03); wr(7, 8'h00);
    wr(18, 8'h01); wr(17, 8'h07); wr(16, 8'h03);
    look(12, 40);
    wr(16, 8'h00); look(12, 6);           // timer 0 stopped: timer 1 frozen
    wr(17, 8'h00); wr(18, 8'h00); wr(19, 8'h03);

    cur_req = "R10";                      // full-width value, ignored writes, unmapped reads
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF);
    for (int i = 0; i < 4; i++) look(i, 1);
    for (int i = 8; i < 12; i++) look(i, 1);
    wr(8, 8'h55); wr(25, 8'hAA); wr(16, 8'hF0);
    look(8, 1); look(16, 1);
    for (int i = 20; i < 32; i++) look(i, 1);

    look(0, 4);
    finish_run();
  end
endmodule